// File: doc/BRIEF.md
# Long Multiply Execution Unit

This unit executes the 32 x 32 long multiply instruction of a CISC core. The issue stage hands it the 16-bit extension word, the source operand, the current value of the destination data register, the instruction address and two configuration inputs. One input says whether the core is the full-featured variant or the reduced embedded variant. The other says whether 64-bit multiply results are supported. The unit returns the low and high product words with a write enable and a register index for each, the N/Z/V/C condition flags, and a request for an unsupported-instruction exception.

The product is formed iteratively. The unit runs a radix-2 shift-and-add over the operand magnitudes, one bit per cycle, and negates the result at the end when a signed multiply has exactly one negative operand. A start pulse is taken only while the unit is idle. Completion is a one-cycle done pulse that coincides with the register write enables and the flag update. A 64-bit request on a core without quad support finishes on the accepting edge and raises the exception instead.

Top module: `mull_unit`

## Requirements
- R1: Extension word decode: bit 11 = 1 selects signed and 0 selects unsigned, bit 10 = 1 selects the 64-bit result form, bits 14:12 give the low-result register index (lo_idx_o) and bits 2:0 give the high-result register index (hi_idx_o); all other bits are ignored.
- R2: In the 64-bit form, done_o pulses with lo_we_o = 1 carrying product bits 31:0 and, when the two indices differ, hi_we_o = 1 carrying product bits 63:32.
- R3: In the 64-bit form with equal low and high indices, only lo_we_o is raised, so the low word is the value that remains in the register.
- R4: In the 64-bit form, N = product bit 63, Z = 1 only when all 64 product bits are zero, and V = C = 0.
- R5: In the 32-bit form on the full variant (full_variant_i = 1), only the low word is written and hi_we_o stays 0. N = bit 31 and Z = (low word == 0). C = 0. V = 1 when bits 63:32 differ from 32 copies of bit 31 (signed) or are nonzero (unsigned).
- R6: In the 32-bit form on the reduced variant (full_variant_i = 0), only the low word is written, N and Z follow the low word, and V = C = 0.
- R7: A 64-bit request with quad_ok_i = 0 raises exc_o together with done_o, reports exc_pc_o = pc_i - 4, writes no register and leaves the flags unchanged.
- R8: A normal operation raises done_o for one cycle on the 33rd (W+1) rising edge after the edge that accepts start_i; an exception raises done_o on the accepting edge itself.
- R9: busy_o is high from the accepting edge until done_o; start_i is ignored while busy_o is high, and the running operation's result is unaffected.
- R10: The flags do not change while busy_o is high, and the write enables are high only in a done cycle without an exception.
- R11: After reset, busy_o, done_o, exc_o and both write enables are 0, and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| ext_i | input | 16 | Instruction extension word |
| src_i | input | W | Source operand |
| dst_i | input | W | Current value of the low-result register |
| pc_i | input | W | Program counter after the instruction words |
| full_variant_i | input | 1 | 1 = full-featured core, 0 = reduced embedded core |
| quad_ok_i | input | 1 | 64-bit result form supported |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | One-cycle completion pulse |
| lo_we_o | output | 1 | Low-word register write enable |
| lo_idx_o | output | 3 | Low-word register index |
| lo_data_o | output | W | Low product word |
| hi_we_o | output | 1 | High-word register write enable |
| hi_idx_o | output | 3 | High-word register index |
| hi_data_o | output | W | High product word |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag |
| exc_o | output | 1 | Unsupported-instruction exception request |
| exc_pc_o | output | W | Address reported with the exception |

## Verification
The bench builds the unit with the default W = 32. At that width the magnitude corners 0x80000000, 0x7FFFFFFF and all-ones hit the full 64-bit product. This exercises both the end negation and the signed overflow test against the discarded upper half. It also fixes the completion latency at 33 edges, so the bench counts that latency exactly for every operation. Table vectors and random operands cover both signedness modes, both result forms, both core variants, equal register indices and the unsupported case.

// File: rtl/mull_pkg.sv
package mull_pkg;
  localparam int unsigned EXT_W      = 16;
  localparam int unsigned IDX_W      = 3;
  localparam int unsigned SIGN_BIT   = 11;
  localparam int unsigned QUAD_BIT   = 10;
  localparam int unsigned LO_IDX_LSB = 12;
  localparam int unsigned HI_IDX_LSB = 0;
  localparam int unsigned PC_BACK    = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} mull_state_e;

  typedef struct packed {
    logic             is_signed;
    logic             quad;
    logic [IDX_W-1:0] lo_idx;
    logic [IDX_W-1:0] hi_idx;
  } mull_op_t;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } mull_ccr_t;
endpackage

// File: rtl/mull_decode.sv
module mull_decode
  import mull_pkg::*;
(
  input  logic [EXT_W-1:0] ext_i,
  output mull_op_t         op_o
);
  logic unused_ext_bits;
  assign unused_ext_bits = ^{ext_i[15], ext_i[9:3]};

  always_comb begin
    op_o.is_signed = ext_i[SIGN_BIT];
    op_o.quad      = ext_i[QUAD_BIT];
    op_o.lo_idx    = ext_i[LO_IDX_LSB +: IDX_W];
    op_o.hi_idx    = ext_i[HI_IDX_LSB +: IDX_W];
  end
endmodule

// File: rtl/mull_shift_add.sv
module mull_shift_add #(
  parameter int unsigned W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_o,
  output logic           last_o
);
  localparam int unsigned CW = $clog2(W);

  logic [CW-1:0]  cnt_q;
  logic [W-1:0]   mcand_q;
  logic [2*W-1:0] prod_q;
  logic [W:0]     sum;

  // add multiplicand into upper half when current multiplier bit is set
  always_comb sum = {1'b0, prod_q[2*W-1:W]} + (prod_q[0] ? {1'b0, mcand_q} : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load_i) begin
      cnt_q   <= '0;
      mcand_q <= mcand_i;
      prod_q  <= {{W{1'b0}}, mplier_i};
    end else if (step_i) begin
      cnt_q   <= cnt_q + 1'b1;
      prod_q  <= {sum, prod_q[W-1:1]};
    end
  end

  assign prod_o = prod_q;
  assign last_o = (cnt_q == CW'(W-1));
endmodule

// File: rtl/mull_result.sv
module mull_result
  import mull_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [2*W-1:0] mag_i,
  input  logic           negate_i,
  input  logic           is_signed_i,
  input  logic           quad_i,
  input  logic           full_i,
  output logic [W-1:0]   lo_o,
  output logic [W-1:0]   hi_o,
  output mull_ccr_t      ccr_o
);
  logic [2*W-1:0] prod;
  logic           ovf;

  always_comb begin
    prod = negate_i ? (~mag_i + 1'b1) : mag_i;
    lo_o = prod[W-1:0];
    hi_o = prod[2*W-1:W];
    ovf  = is_signed_i ? (hi_o != {W{lo_o[W-1]}}) : (hi_o != '0);
    if (quad_i) begin
      ccr_o.n = prod[2*W-1];
      ccr_o.z = (prod == '0);
      ccr_o.v = 1'b0;
    end else begin
      ccr_o.n = lo_o[W-1];
      ccr_o.z = (lo_o == '0);
      ccr_o.v = full_i & ovf;
    end
    ccr_o.c = 1'b0;
  end
endmodule

// File: rtl/mull_unit.sv
module mull_unit
  import mull_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [EXT_W-1:0] ext_i,
  input  logic [W-1:0]     src_i,
  input  logic [W-1:0]     dst_i,
  input  logic [W-1:0]     pc_i,
  input  logic             full_variant_i,
  input  logic             quad_ok_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             lo_we_o,
  output logic [IDX_W-1:0] lo_idx_o,
  output logic [W-1:0]     lo_data_o,
  output logic             hi_we_o,
  output logic [IDX_W-1:0] hi_idx_o,
  output logic [W-1:0]     hi_data_o,
  output logic             flag_n_o,
  output logic             flag_z_o,
  output logic             flag_v_o,
  output logic             flag_c_o,
  output logic             exc_o,
  output logic [W-1:0]     exc_pc_o
);
  mull_state_e    state_q;
  mull_op_t       dec_op, op_q;
  logic           full_q, neg_q;
  logic           accept, trap, load;
  logic [W-1:0]   src_mag, dst_mag;
  logic [2*W-1:0] mag;
  logic           last;
  logic [W-1:0]   res_lo, res_hi;
  mull_ccr_t      res_ccr, ccr_q;

  mull_decode u_dec (.ext_i(ext_i), .op_o(dec_op));

  assign accept = start_i && (state_q == ST_IDLE);
  assign trap   = accept && dec_op.quad && !quad_ok_i;
  assign load   = accept && !trap;

  always_comb begin
    src_mag = (dec_op.is_signed && src_i[W-1]) ? (~src_i + 1'b1) : src_i;
    dst_mag = (dec_op.is_signed && dst_i[W-1]) ? (~dst_i + 1'b1) : dst_i;
  end

  mull_shift_add #(.W(W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (state_q == ST_RUN),
    .mcand_i (src_mag),
    .mplier_i(dst_mag),
    .prod_o  (mag),
    .last_o  (last)
  );

  mull_result #(.W(W)) u_res (
    .mag_i      (mag),
    .negate_i   (neg_q),
    .is_signed_i(op_q.is_signed),
    .quad_i     (op_q.quad),
    .full_i     (full_q),
    .lo_o       (res_lo),
    .hi_o       (res_hi),
    .ccr_o      (res_ccr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_q      <= '0;
      full_q    <= 1'b0;
      neg_q     <= 1'b0;
      done_o    <= 1'b0;
      exc_o     <= 1'b0;
      exc_pc_o  <= '0;
      lo_we_o   <= 1'b0;
      hi_we_o   <= 1'b0;
      lo_idx_o  <= '0;
      hi_idx_o  <= '0;
      lo_data_o <= '0;
      hi_data_o <= '0;
      ccr_q     <= '0;
    end else begin
      done_o  <= 1'b0;
      exc_o   <= 1'b0;
      lo_we_o <= 1'b0;
      hi_we_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (trap) begin
            done_o   <= 1'b1;
            exc_o    <= 1'b1;
            exc_pc_o <= pc_i - W'(PC_BACK);
          end else if (load) begin
            op_q    <= dec_op;
            full_q  <= full_variant_i;
            neg_q   <= dec_op.is_signed & (src_i[W-1] ^ dst_i[W-1]);
            state_q <= ST_RUN;
          end
        end
        ST_RUN: if (last) state_q <= ST_FIN;
        ST_FIN: begin
          done_o    <= 1'b1;
          lo_we_o   <= 1'b1;
          lo_idx_o  <= op_q.lo_idx;
          lo_data_o <= res_lo;
          // equal indices: drop the high write so the low word survives
          hi_we_o   <= op_q.quad && (op_q.hi_idx != op_q.lo_idx);
          hi_idx_o  <= op_q.hi_idx;
          hi_data_o <= res_hi;
          ccr_q     <= res_ccr;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign flag_n_o = ccr_q.n;
  assign flag_z_o = ccr_q.z;
  assign flag_v_o = ccr_q.v;
  assign flag_c_o = ccr_q.c;
endmodule

// File: rtl/mull_unit_chk.sv
module mull_unit_chk #(
  parameter int unsigned W = 32
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       lo_we_o,
  input logic       hi_we_o,
  input logic [2:0] lo_idx_o,
  input logic [2:0] hi_idx_o,
  input logic       flag_n_o,
  input logic       flag_z_o,
  input logic       flag_v_o,
  input logic       flag_c_o,
  input logic       exc_o
);
  localparam int unsigned RW = $clog2(W + 2) + 1;
  logic [RW-1:0] run_len_q;
  logic [3:0]    flags;

  assign flags = {flag_n_o, flag_z_o, flag_v_o, flag_c_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_len_q <= '0;
    else if (busy_o) run_len_q <= run_len_q + 1'b1;
    else             run_len_q <= '0;
  end

  p_same_reg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_we_o |-> (hi_idx_o != lo_idx_o));

  p_exc_no_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> (done_o && !lo_we_o && !hi_we_o));

  p_exc_flags_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> $stable(flags));

  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !exc_o) |-> (run_len_q == RW'(W + 1)));

  p_busy_from_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  p_no_done_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);

  p_flags_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $stable(flags));

  p_we_in_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_we_o || hi_we_o) |-> (done_o && !exc_o));

  p_c_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_c_o);
endmodule

bind mull_unit mull_unit_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .lo_we_o (lo_we_o),
  .hi_we_o (hi_we_o),
  .lo_idx_o(lo_idx_o),
  .hi_idx_o(hi_idx_o),
  .flag_n_o(flag_n_o),
  .flag_z_o(flag_z_o),
  .flag_v_o(flag_v_o),
  .flag_c_o(flag_c_o),
  .exc_o   (exc_o)
);

// File: tb/mull_unit_tb.sv
module mull_unit_tb_top;
  localparam int unsigned W = 32;
  localparam int NV = 18;

  typedef struct packed {
    logic [15:0] ext;
    logic [31:0] src;
    logic [31:0] dst;
    logic        full;
    logic        qok;
  } vec_t;

  // ext: [14:12] low idx, [11] signed, [10] 64-bit form, [2:0] high idx
  localparam vec_t VECS [NV] = '{
    '{16'h2C05, 32'hFFFFFFFF, 32'h00000001, 1'b1, 1'b1},
    '{16'h4406, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b1},
    '{16'h2C05, 32'h80000000, 32'h80000000, 1'b1, 1'b1},
    '{16'h2C05, 32'h80000000, 32'h7FFFFFFF, 1'b1, 1'b1},
    '{16'h4406, 32'h00000000, 32'h12345678, 1'b1, 1'b1},
    '{16'h7C07, 32'h12345678, 32'h9ABCDEF0, 1'b1, 1'b1},
    '{16'h1800, 32'h7FFFFFFF, 32'h00000002, 1'b1, 1'b1},
    '{16'h1800, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b1},
    '{16'h3000, 32'hFFFFFFFF, 32'h00000002, 1'b1, 1'b1},
    '{16'h3000, 32'h00010000, 32'h00010000, 1'b1, 1'b1},
    '{16'h1800, 32'h80000000, 32'h00000001, 1'b1, 1'b1},
    '{16'h1800, 32'h7FFFFFFF, 32'h00000002, 1'b0, 1'b1},
    '{16'h3000, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b1},
    '{16'h2C05, 32'h00000003, 32'hFFFFFFFD, 1'b0, 1'b1},
    '{16'h2C05, 32'h00000001, 32'h00000001, 1'b0, 1'b0},
    '{16'h4406, 32'h00000005, 32'h00000005, 1'b1, 1'b0},
    '{16'h0C01, 32'hDEADBEEF, 32'hCAFEBABE, 1'b1, 1'b1},
    '{16'h5800, 32'h00000001, 32'h00000000, 1'b1, 1'b1}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] ext_i = '0;
  logic [31:0] src_i = '0, dst_i = '0, pc_i = '0;
  logic        full_variant_i = 1'b1, quad_ok_i = 1'b1;
  logic        busy_o, done_o, lo_we_o, hi_we_o, exc_o;
  logic [2:0]  lo_idx_o, hi_idx_o;
  logic [31:0] lo_data_o, hi_data_o, exc_pc_o;
  logic        flag_n_o, flag_z_o, flag_v_o, flag_c_o;

  int checks = 0;
  int fails  = 0;
  logic [3:0] prev_flags = 4'b0;

  always #5 clk_i = ~clk_i;

  mull_unit #(.W(W)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] ext, input logic [31:0] s, input logic [31:0] d,
                        input logic full, input logic qok, input bit poke);
    logic signed [63:0] sa, da;
    logic [63:0] p;
    logic sg, qd, exc, ewl, ewh;
    logic [3:0] ef;
    logic [31:0] pc;
    int cnt;
    sg = ext[11]; qd = ext[10];
    sa = {{32{s[31]}}, s}; da = {{32{d[31]}}, d};
    p  = sg ? 64'(sa * da) : ({32'b0, s} * {32'b0, d});
    exc = qd & ~qok;
    pc  = $urandom;
    ewl = !exc;
    ewh = !exc && qd && (ext[14:12] != ext[2:0]);
    if (exc)     ef = prev_flags;
    else if (qd) ef = {p[63], p == 64'd0, 1'b0, 1'b0};
    else         ef = {p[31], p[31:0] == 32'd0,
                       full & (sg ? (p[63:32] != {32{p[31]}}) : (p[63:32] != 32'd0)), 1'b0};
    @(negedge clk_i);
    ext_i = ext; src_i = s; dst_i = d; full_variant_i = full; quad_ok_i = qok; pc_i = pc;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    cnt = 1;
    while (!done_o && cnt < 100) begin
      if (poke && cnt == 3) begin
        chk(busy_o == 1'b1, "R9 busy", 64'(busy_o), 64'd1);
        chk({flag_n_o, flag_z_o, flag_v_o, flag_c_o} == prev_flags, "R10 flags hold",
            64'({flag_n_o, flag_z_o, flag_v_o, flag_c_o}), 64'(prev_flags));
        ext_i = ~ext; src_i = ~s; dst_i = s ^ 32'h5A5A5A5A; start_i = 1'b1;
      end else start_i = 1'b0;
      @(negedge clk_i);
      cnt++;
    end
    start_i = 1'b0;
    chk(cnt == (exc ? 1 : int'(W) + 2), "R8 latency", 64'(cnt), exc ? 64'd1 : 64'(W + 2));
    chk(done_o == 1'b1, "R8 done", 64'(done_o), 64'd1);
    chk(exc_o == exc, "R7 exc", 64'(exc_o), 64'(exc));
    if (exc) chk(exc_pc_o == pc - 32'd4, "R7 exc_pc", 64'(exc_pc_o), 64'(pc - 32'd4));
    chk(lo_we_o == ewl, "R2 lo_we", 64'(lo_we_o), 64'(ewl));
    chk(hi_we_o == ewh, (qd && ext[14:12] == ext[2:0]) ? "R3 hi_we" : "R5 hi_we",
        64'(hi_we_o), 64'(ewh));
    if (ewl) begin
      chk(lo_idx_o == ext[14:12], "R1 lo_idx", 64'(lo_idx_o), 64'(ext[14:12]));
      chk(lo_data_o == p[31:0], qd ? "R2 lo_data" : "R5 lo_data", 64'(lo_data_o), 64'(p[31:0]));
    end
    if (ewh) begin
      chk(hi_idx_o == ext[2:0], "R1 hi_idx", 64'(hi_idx_o), 64'(ext[2:0]));
      chk(hi_data_o == p[63:32], "R2 hi_data", 64'(hi_data_o), 64'(p[63:32]));
    end
    chk({flag_n_o, flag_z_o, flag_v_o, flag_c_o} == ef,
        exc ? "R7 flags" : (qd ? "R4 flags" : (full ? "R5 flags" : "R6 flags")),
        64'({flag_n_o, flag_z_o, flag_v_o, flag_c_o}), 64'(ef));
    prev_flags = ef;
    @(negedge clk_i);
    chk(done_o == 1'b0 && lo_we_o == 1'b0, "R10 pulse", 64'({done_o, lo_we_o}), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] corners [5];
    corners = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h80000000, 32'h7FFFFFFF};
    repeat (3) @(negedge clk_i);
    // R11: reset state
    chk({busy_o, done_o, exc_o, lo_we_o, hi_we_o} == 5'b0, "R11 ctrl",
        64'({busy_o, done_o, exc_o, lo_we_o, hi_we_o}), 64'd0);
    chk({flag_n_o, flag_z_o, flag_v_o, flag_c_o} == 4'b0, "R11 flags",
        64'({flag_n_o, flag_z_o, flag_v_o, flag_c_o}), 64'd0);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++)
      run_op(VECS[i].ext, VECS[i].src, VECS[i].dst, VECS[i].full, VECS[i].qok, 1'b0);
    // R9: start pulses during a run are ignored
    run_op(16'h2C05, 32'h80000000, 32'h00000003, 1'b1, 1'b1, 1'b1);
    run_op(16'h1800, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b1, 1'b1, 1'b1);
    // R1: unused extension bits set
    run_op(16'hBFF8 & 16'hFBFF | 16'h0002, 32'h00001234, 32'hFFFF0000, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 48; i++) begin
      logic [31:0] a, b;
      a = (i % 3 == 0) ? corners[$urandom % 5] : $urandom;
      b = (i % 4 == 1) ? corners[$urandom % 5] : $urandom;
      run_op(16'($urandom), a, b, 1'($urandom), (i % 5 != 0), 1'b0);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule